// File: doc/BRIEF.md
# PS/2 Keyboard Scancode Receiver

This block listens to the clock and data lines of a PS/2 keyboard and turns the serial traffic into key-press events for the rest of the chip. Both keyboard lines are treated as asynchronous. Each line passes through a flip-flop synchronizer and a small stability filter. The receiver samples data on every filtered falling edge of the keyboard clock.

Each 11-bit frame is assembled and its start and stop bits are checked. The parity bit is not used, so a byte with a wrong parity bit is still delivered. A tracker for the key-release protocol swallows the release prefix and the code that follows it. As a result, each key press appears exactly once on the output as a one-cycle strobe with the 8-bit code. Malformed frames raise a one-cycle error flag. A frame left unfinished for too long is abandoned, so it cannot spoil the next frame.

Top module: `kbd_scan_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `scan_code` is 0x00 and `scan_vld` and `frame_err` are low.
- R2: A frame is a 0 start bit, eight data bits least significant bit first, one parity bit, and a 1 stop bit. Each bit is sampled on a falling edge of `kbd_clk`. A good frame carrying a byte other than 0xF0, with no release pending, produces exactly one `scan_vld` cycle with that byte on `scan_code`.
- R3: The value of the parity bit has no effect on delivery.
- R4: A received 0xF0 is never reported. The byte that follows it is not reported either. The byte after that is handled normally again.
- R5: A falling edge whose start bit reads 1 raises `frame_err` for one cycle. Nothing is reported, and the receiver keeps waiting for a start bit.
- R6: A frame whose stop bit reads 0 raises `frame_err` for one cycle, and its byte is dropped.
- R7: If a frame has begun and no falling edge arrives for `TIMEOUT_CYC` cycles, the partial frame is discarded. The next complete frame is then received correctly.
- R8: A pulse on `kbd_clk` that lasts fewer than `FILT_LEN` system cycles is ignored.
- R9: `scan_vld` is high for one cycle per report. `scan_code` changes only in a cycle where `scan_vld` is high.
- R10: Frames that follow each other with only half a keyboard clock period of idle between them are all received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kbd_clk | input | 1 | Keyboard clock line, asynchronous, idles high |
| kbd_dat | input | 1 | Keyboard data line, asynchronous, idles high |
| scan_code | output | 8 | Last reported make code |
| scan_vld | output | 1 | One-cycle strobe for a new key press |
| frame_err | output | 1 | One-cycle strobe for a bad start or stop bit |

## Verification
The bench builds the receiver with two synchronizer stages, a three-cycle filter and a 1500-cycle timeout. It drives the keyboard clock with a half period of 20 system cycles. The shorter timeout lets an abandoned frame expire within a few thousand cycles. A one-cycle spike on the keyboard clock is shorter than the three-cycle filter, so the bench can show that it is ignored. At this scale, random codes, random parity values, release sequences, back-to-back frames and both framing errors all fit well inside the cycle budget.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  localparam int          CODE_W     = 8;
  localparam int          FRAME_BITS = 11;
  localparam int          BITCNT_W   = $clog2(FRAME_BITS);
  localparam logic [7:0]  REL_PREFIX = 8'hF0;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          stab_cnt;
  logic                   filt_q;

  // Filtered level follows the synchronized line only after FILT_LEN
  // consecutive cycles of disagreement.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '1;
      stab_cnt <= '0;
      filt_q   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (sync_q[SYNC_STAGES-1] != filt_q) begin
        if (stab_cnt == CW'(FILT_LEN - 1)) begin
          filt_q   <= sync_q[SYNC_STAGES-1];
          stab_cnt <= '0;
        end else begin
          stab_cnt <= stab_cnt + 1'b1;
        end
      end else begin
        stab_cnt <= '0;
      end
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 200000
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  kclk_i,
  input  logic  kdat_i,
  output code_t byte_o,
  output logic  byte_vld_o,
  output logic  err_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic                kclk_d;
  logic                fall;
  logic [BITCNT_W-1:0] bit_cnt;
  logic [TW-1:0]       idle_tmr;
  code_t               shreg;

  assign fall = kclk_d & ~kclk_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      kclk_d     <= 1'b1;
      bit_cnt    <= '0;
      idle_tmr   <= '0;
      shreg      <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      kclk_d     <= kclk_i;
      byte_vld_o <= 1'b0;
      err_o      <= 1'b0;
      if (fall) begin
        idle_tmr <= '0;
        if (bit_cnt == '0) begin
          if (!kdat_i) bit_cnt <= BITCNT_W'(1);
          else         err_o   <= 1'b1;
        end else if (bit_cnt <= BITCNT_W'(CODE_W)) begin
          shreg   <= {kdat_i, shreg[CODE_W-1:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (bit_cnt == BITCNT_W'(FRAME_BITS - 2)) begin
          bit_cnt <= bit_cnt + 1'b1;          // parity slot, value unused
        end else begin
          bit_cnt <= '0;
          if (kdat_i) begin
            byte_o     <= shreg;
            byte_vld_o <= 1'b1;
          end else begin
            err_o <= 1'b1;
          end
        end
      end else if (bit_cnt != '0) begin
        if (idle_tmr == TW'(TIMEOUT_CYC - 1)) begin
          bit_cnt  <= '0;
          idle_tmr <= '0;
        end else begin
          idle_tmr <= idle_tmr + 1'b1;
        end
      end else begin
        idle_tmr <= '0;
      end
    end
  end
endmodule

// File: rtl/kbd_break_filter.sv
module kbd_break_filter
  import kbd_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  code_t byte_i,
  input  logic  byte_vld_i,
  output code_t code_o,
  output logic  code_vld_o
);
  logic rel_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_pend   <= 1'b0;
      code_o     <= '0;
      code_vld_o <= 1'b0;
    end else begin
      code_vld_o <= 1'b0;
      if (byte_vld_i) begin
        if (byte_i == REL_PREFIX) begin
          rel_pend <= 1'b1;
        end else if (rel_pend) begin
          rel_pend <= 1'b0;
        end else begin
          code_o     <= byte_i;
          code_vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kbd_scan_rx.sv
module kbd_scan_rx
  import kbd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8,
  parameter int TIMEOUT_CYC = 200000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kbd_clk,
  input  logic       kbd_dat,
  output logic [7:0] scan_code,
  output logic       scan_vld,
  output logic       frame_err
);
  logic [1:0] raw_lines;
  logic [1:0] clean_lines;
  code_t      rx_byte;
  logic       rx_vld;

  assign raw_lines = {kbd_dat, kbd_clk};

  for (genvar g = 0; g < 2; g++) begin : g_line
    kbd_line_sync #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sync (
      .clk(clk), .rst(rst), .line_i(raw_lines[g]), .line_o(clean_lines[g])
    );
  end

  kbd_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
    .clk(clk), .rst(rst),
    .kclk_i(clean_lines[0]), .kdat_i(clean_lines[1]),
    .byte_o(rx_byte), .byte_vld_o(rx_vld), .err_o(frame_err)
  );

  kbd_break_filter u_brk (
    .clk(clk), .rst(rst),
    .byte_i(rx_byte), .byte_vld_i(rx_vld),
    .code_o(scan_code), .code_vld_o(scan_vld)
  );
endmodule

// File: rtl/kbd_scan_rx_chk.sv
module kbd_scan_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] scan_code,
  input logic       scan_vld,
  input logic       frame_err,
  input logic [7:0] rx_byte,
  input logic       rx_vld
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!scan_vld && !frame_err && scan_code == 8'h00));

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    scan_vld |=> !scan_vld);

  a_r9_code_hold: assert property (@(posedge clk) disable iff (rst)
    !scan_vld |-> $stable(scan_code));

  a_r4_no_prefix_out: assert property (@(posedge clk) disable iff (rst)
    scan_vld |-> scan_code != 8'hF0);

  a_r4_prefix_swallowed: assert property (@(posedge clk) disable iff (rst)
    (rx_vld && rx_byte == 8'hF0) |=> !scan_vld);

  a_r5_err_single: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  a_r6_err_no_report: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> !rx_vld);
endmodule

bind kbd_scan_rx kbd_scan_rx_chk u_chk (
  .clk(clk), .rst(rst), .scan_code(scan_code), .scan_vld(scan_vld),
  .frame_err(frame_err), .rx_byte(rx_byte), .rx_vld(rx_vld)
);

// File: tb/kbd_scan_rx_tb.sv
module kbd_scan_rx_tb;
  localparam int HP = 20;          // keyboard clock half period in cycles

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kbd_clk = 1'b1;
  logic       kbd_dat = 1'b1;
  logic [7:0] scan_code;
  logic       scan_vld;
  logic       frame_err;

  int total = 0;
  int bad   = 0;
  int nvld  = 0;
  int nerr  = 0;
  logic [7:0] last_code = 8'h00;
  bit m_rel = 1'b0;
  bit done  = 1'b0;

  always #10 clk = ~clk;           // 50 MHz

  kbd_scan_rx #(.SYNC_STAGES(2), .FILT_LEN(3), .TIMEOUT_CYC(1500)) u_dut (
    .clk(clk), .rst(rst), .kbd_clk(kbd_clk), .kbd_dat(kbd_dat),
    .scan_code(scan_code), .scan_vld(scan_vld), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (scan_vld) begin nvld++; last_code = scan_code; end
      if (frame_err) nerr++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the release tracker: returns 1 if the byte is reported
  function automatic bit model_byte(input logic [7:0] b);
    if (b == 8'hF0) begin m_rel = 1'b1; return 1'b0; end
    if (m_rel) begin m_rel = 1'b0; return 1'b0; end
    return 1'b1;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic v, input bit glitch);
    wait_cyc(HP); kbd_dat = v; kbd_clk = 1'b1;
    if (glitch) begin
      wait_cyc(HP/2); kbd_clk = 1'b0; wait_cyc(1); kbd_clk = 1'b1;
      wait_cyc(HP - HP/2 - 1);
    end else begin
      wait_cyc(HP);
    end
    kbd_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stb, input logic par,
                            input logic stp, input bit glitch, input int gap);
    kbd_dat = stb;
    wait_cyc(HP); kbd_clk = 1'b0;
    for (int j = 0; j < 8; j++) clk_bit(b[j], glitch && j == 3);
    clk_bit(par, 1'b0);
    clk_bit(stp, 1'b0);
    wait_cyc(HP); kbd_clk = 1'b1; kbd_dat = 1'b1;
    wait_cyc(gap);
  endtask

  task automatic good_frame(input logic [7:0] b, input logic par, input int gap);
    send_frame(b, 1'b0, par, 1'b1, 1'b0, gap);
  endtask

  task automatic expect_press(input string req, input logic [7:0] code, input int n0);
    chk(req, nvld - n0, 1);
    chk(req, last_code, code);
  endtask

  initial begin
    int n0;
    int e0;
    logic [7:0] c;
    logic p;
    void'($urandom(32'd20240611));
    wait_cyc(3);
    chk("R1 code", scan_code, 0);
    chk("R1 vld", scan_vld, 0);
    chk("R1 err", frame_err, 0);
    rst = 1'b0;
    wait_cyc(1);
    chk("R1 after", {scan_vld, frame_err}, 0);
    wait_cyc(50);

    // R2/R4: press and release A, B, Y with long idle gaps
    n0 = nvld;
    good_frame(8'h1C, 1'b0, 400);
    expect_press("R2 key A", 8'h1C, n0);
    void'(model_byte(8'h1C));
    good_frame(8'hF0, 1'b0, 400); void'(model_byte(8'hF0));
    good_frame(8'h1C, 1'b0, 400); void'(model_byte(8'h1C));
    chk("R4 release A hidden", nvld - n0, 1);
    n0 = nvld;
    good_frame(8'h32, 1'b1, 400); void'(model_byte(8'h32));
    expect_press("R3 key B odd parity", 8'h32, n0);

    // R10: back-to-back frames, half period gap
    n0 = nvld;
    good_frame(8'hF0, 1'b0, HP/2); void'(model_byte(8'hF0));
    good_frame(8'h32, 1'b0, HP/2); void'(model_byte(8'h32));
    good_frame(8'h35, 1'b0, HP/2); void'(model_byte(8'h35));
    good_frame(8'hF0, 1'b0, HP/2); void'(model_byte(8'hF0));
    good_frame(8'h35, 1'b0, 100);  void'(model_byte(8'h35));
    expect_press("R10 key Y back-to-back", 8'h35, n0);

    // R5: lone falling edge with data high at start position
    n0 = nvld; e0 = nerr;
    kbd_dat = 1'b1; wait_cyc(HP); kbd_clk = 1'b0; wait_cyc(HP); kbd_clk = 1'b1;
    wait_cyc(100);
    chk("R5 start error", nerr - e0, 1);
    chk("R5 no report", nvld - n0, 0);
    good_frame(8'h2A, 1'b0, 100); void'(model_byte(8'h2A));
    expect_press("R5 recovered", 8'h2A, n0);

    // R6: bad stop bit
    n0 = nvld; e0 = nerr;
    send_frame(8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 100);
    chk("R6 stop error", nerr - e0, 1);
    chk("R6 byte dropped", nvld - n0, 0);

    // R7: partial frame then timeout
    n0 = nvld;
    kbd_dat = 1'b0; wait_cyc(HP); kbd_clk = 1'b0;
    for (int j = 0; j < 4; j++) clk_bit(1'b1, 1'b0);
    wait_cyc(HP); kbd_clk = 1'b1; kbd_dat = 1'b1;
    wait_cyc(2000);
    good_frame(8'h5B, 1'b0, 100); void'(model_byte(8'h5B));
    expect_press("R7 after timeout", 8'h5B, n0);

    // R8: glitch on keyboard clock in mid-frame
    n0 = nvld;
    send_frame(8'h69, 1'b0, 1'b1, 1'b1, 1'b1, 100); void'(model_byte(8'h69));
    expect_press("R8 glitch ignored", 8'h69, n0);

    // random codes and parity with optional release sequences
    for (int i = 0; i < 16; i++) begin
      c = 8'($urandom);
      if (c == 8'hF0) c = 8'h1C;
      p = 1'($urandom);
      n0 = nvld;
      good_frame(c, p, HP/2 + 8'($urandom % 60));
      if (model_byte(c)) expect_press("R2 random", c, n0);
      else chk("R4 random hidden", nvld - n0, 0);
      if ($urandom % 2 == 1) begin
        n0 = nvld;
        good_frame(8'hF0, ~p, HP/2); void'(model_byte(8'hF0));
        good_frame(c, p, 100);       void'(model_byte(c));
        chk("R4 random release", nvld - n0, 0);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule